// File: doc/BRIEF.md
# Byte-Lane Error-Correcting Static Memory

This block is a synchronous on-chip memory with an 18-bit word address and a 16-bit data word, split into two independent 8-bit byte lanes. Each lane keeps its own 4-bit Hamming check field beside its data, so every lane is held as a 12-bit codeword. A write encodes only the lanes whose byte enable is asserted and leaves the other lane's codeword alone. A byte-masked write therefore never has to read back and re-encode the neighbouring byte.

On a read, each lane's codeword is captured on the clock edge and decoded on its own. A single flipped bit is repaired and reported on a per-lane flag. A syndrome that cannot name a real bit position is reported as uncorrectable. Chip select, output enable, write enable and the two byte enables are all active low. A lane that is not being driven presents zero data together with a low drive-enable bit, and that bit serves as the high-impedance control. Storage depth is a parameter, and the upper address bits beyond that depth are not decoded.

A test-only port flips one chosen bit of one stored codeword, so errors can be planted and the correction path exercised.

Top module: `bytelane_ecc_ram`

## Requirements
- R1: With `ce_n`=0 and `we_n`=0, each lane whose byte enable is low (`lb_n` for bits 7:0, `ub_n` for bits 15:8) stores the encoded write data, and a lane whose byte enable is high keeps its old contents; `oe_n` has no effect on writes.
- R2: With `ce_n`=0 and `we_n`=1, the word at the address is captured on the clock edge and appears on `rdata` in the following cycle. A lane's `rd_drive` bit is then 1 only if `oe_n` and that lane's byte enable were both low at the edge.
- R3: With `ce_n`=1, no write occurs and `rd_drive` is 0 in the next cycle.
- R4: A lane whose `rd_drive` bit is 0 shows 0 on its `rdata` bits and 0 on its flags; `oe_n`=1 at a read edge leaves both lanes undriven.
- R5: If exactly one of the 12 codeword bits of a lane is inverted, the read returns the original byte and raises that lane's `sec_flag` bit (bit 0 lower, bit 1 upper) for that one cycle. The other lane's flags are unaffected.
- R6: If a lane's syndrome is 13, 14 or 15, that lane's `unc_flag` bit is raised, its `sec_flag` bit is low, and the byte is returned as stored, without correction.
- R7: With `inj_en`=1 on a clock edge, the stored codeword of lane `inj_lane` at `addr` has bit position `inj_pos` inverted (valid positions 1 to 12; 0, 13, 14 and 15 change nothing). No read or write takes place in that cycle.
- R8: While `rst` is high, and in the cycle after it, `rd_drive`, `rdata`, `sec_flag` and `unc_flag` are all 0.
- R9: Codeword positions 1, 2, 4 and 8 hold the check bits. Data bits 0 to 7 occupy positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. The syndrome is the XOR of the positions of all set bits and is zero for a valid codeword.
- R10: Only the low `MEM_AW` address bits select a word; addresses that differ only above them reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output state |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write when low, read when high |
| lb_n | input | 1 | Lower byte lane enable, active low |
| ub_n | input | 1 | Upper byte lane enable, active low |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write data |
| inj_en | input | 1 | Test: invert one stored codeword bit |
| inj_lane | input | 1 | Test: lane to corrupt (0 lower, 1 upper) |
| inj_pos | input | 4 | Test: codeword position to invert (1 to 12) |
| rdata | output | 16 | Read data, zero in undriven lanes |
| rd_drive | output | 2 | Per-lane bus drive enable (0 means high impedance) |
| sec_flag | output | 2 | Per-lane single error corrected |
| unc_flag | output | 2 | Per-lane uncorrectable syndrome |

## Verification
The states that are hardest to reach are stored words whose codewords disagree with their data, because a normal write always stores a clean codeword. The bench uses the injection port to invert every position of every lane at every word of a 16-word configuration, then reads the word back and injects again to restore it. Uncorrectable cases are reached by planting every position pair whose XOR is 13 to 15. The data returned in those cases also exposes the bit layout, since each planted data position shows up as one raw flipped bit.

// File: rtl/bytelane_ecc_pkg.sv
package bytelane_ecc_pkg;

    localparam int LANES   = 2;
    localparam int LANE_DW = 8;
    localparam int CODE_W  = 12;
    localparam int SYN_W   = 4;

    typedef logic [CODE_W-1:0]  codeword_t;
    typedef logic [LANE_DW-1:0] lane_byte_t;
    typedef logic [SYN_W-1:0]   syndrome_t;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_READ   = 2'd1,
        OP_WRITE  = 2'd2,
        OP_INJECT = 2'd3
    } mem_op_e;

    typedef struct packed {
        lane_byte_t data;
        logic       sec;
        logic       unc;
    } lane_result_t;

    function automatic logic pos_is_check(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // XOR of the positions (1-based) of all set bits
    function automatic syndrome_t syndrome_of(input codeword_t cw);
        syndrome_t s;
        s = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (cw[p-1]) s = s ^ SYN_W'(p);
        end
        return s;
    endfunction

    function automatic codeword_t encode_byte(input lane_byte_t d);
        codeword_t cw;
        syndrome_t s;
        int        k;
        cw = '0;
        k  = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!pos_is_check(p)) begin
                cw[p-1] = d[k];
                k++;
            end
        end
        s = syndrome_of(cw);
        for (int b = 0; b < SYN_W; b++) begin
            cw[(1 << b) - 1] = s[b];
        end
        return cw;
    endfunction

    function automatic lane_byte_t extract_byte(input codeword_t cw);
        lane_byte_t d;
        int         k;
        d = '0;
        k = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!pos_is_check(p)) begin
                d[k] = cw[p-1];
                k++;
            end
        end
        return d;
    endfunction

    function automatic codeword_t pos_mask(input syndrome_t pos);
        if (pos == '0 || int'(pos) > CODE_W) return '0;
        return codeword_t'(1) << (pos - 1'b1);
    endfunction

endpackage

// File: rtl/bytelane_ecc_ctrl.sv
module bytelane_ecc_ctrl
    import bytelane_ecc_pkg::*;
(
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic             lb_n,
    input  logic             ub_n,
    input  logic             inj_en,
    output mem_op_e          op,
    output logic [LANES-1:0] lane_wr,
    output logic [LANES-1:0] lane_show
);

    logic [LANES-1:0] lane_sel;

    always_comb begin
        lane_sel = {~ub_n, ~lb_n};
        if (inj_en)     op = OP_INJECT;
        else if (ce_n)  op = OP_IDLE;
        else if (!we_n) op = OP_WRITE;
        else            op = OP_READ;

        lane_wr   = (op == OP_WRITE) ? lane_sel : '0;
        lane_show = (op == OP_READ && !oe_n) ? lane_sel : '0;
    end

endmodule

// File: rtl/bytelane_ecc_store.sv
module bytelane_ecc_store
    import bytelane_ecc_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic [MEM_AW-1:0] idx,
    input  logic              wr_en,
    input  codeword_t         wr_cw,
    input  logic              rd_en,
    input  logic              flip_en,
    input  syndrome_t         flip_pos,
    output codeword_t         rd_cw
);

    localparam int DEPTH = 1 << MEM_AW;

    codeword_t mem [DEPTH];
    codeword_t flip_mask;

    always_comb flip_mask = pos_mask(flip_pos);

    always_ff @(posedge clk) begin
        if (flip_en) begin
            mem[idx] <= mem[idx] ^ flip_mask;
        end else if (wr_en) begin
            mem[idx] <= wr_cw;
        end
        if (rd_en) begin
            rd_cw <= mem[idx];
        end
    end

endmodule

// File: rtl/bytelane_ecc_decode.sv
module bytelane_ecc_decode
    import bytelane_ecc_pkg::*;
(
    input  codeword_t    cw,
    output lane_result_t res
);

    syndrome_t syn;
    logic      in_range;

    always_comb begin
        syn      = syndrome_of(cw);
        in_range = int'(syn) <= CODE_W;
        res.sec  = (syn != '0) && in_range;
        res.unc  = (syn != '0) && !in_range;
        if (res.sec) res.data = extract_byte(cw ^ pos_mask(syn));
        else         res.data = extract_byte(cw);
    end

endmodule

// File: rtl/bytelane_ecc_ram.sv
module bytelane_ecc_ram
    import bytelane_ecc_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              inj_en,
    input  logic              inj_lane,
    input  logic [3:0]        inj_pos,
    output logic [15:0]       rdata,
    output logic [1:0]        rd_drive,
    output logic [1:0]        sec_flag,
    output logic [1:0]        unc_flag
);

    mem_op_e          op;
    logic [LANES-1:0] lane_wr;
    logic [LANES-1:0] lane_show;
    logic [LANES-1:0] drive_q;
    logic [MEM_AW-1:0] idx;

    assign idx = addr[MEM_AW-1:0];

    generate
        if (MEM_AW < ADDR_W) begin : g_high_addr
            logic unused_high_addr;
            assign unused_high_addr = ^addr[ADDR_W-1:MEM_AW];
        end
    endgenerate

    bytelane_ecc_ctrl u_ctrl (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .lb_n      (lb_n),
        .ub_n      (ub_n),
        .inj_en    (inj_en),
        .op        (op),
        .lane_wr   (lane_wr),
        .lane_show (lane_show)
    );

    always_ff @(posedge clk) begin
        if (rst) drive_q <= '0;
        else     drive_q <= lane_show;
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            codeword_t    enc_cw;
            codeword_t    rd_cw;
            lane_result_t res;
            logic         flip_here;

            assign enc_cw    = encode_byte(wdata[l*LANE_DW +: LANE_DW]);
            assign flip_here = (op == OP_INJECT) && (inj_lane == l[0]);

            bytelane_ecc_store #(.MEM_AW(MEM_AW)) u_store (
                .clk      (clk),
                .idx      (idx),
                .wr_en    (lane_wr[l]),
                .wr_cw    (enc_cw),
                .rd_en    (op == OP_READ),
                .flip_en  (flip_here),
                .flip_pos (inj_pos),
                .rd_cw    (rd_cw)
            );

            bytelane_ecc_decode u_dec (
                .cw  (rd_cw),
                .res (res)
            );

            assign rdata[l*LANE_DW +: LANE_DW] = drive_q[l] ? res.data : '0;
            assign sec_flag[l] = drive_q[l] & res.sec;
            assign unc_flag[l] = drive_q[l] & res.unc;
        end
    endgenerate

    assign rd_drive = drive_q;

endmodule

// File: rtl/bytelane_ecc_chk.sv
module bytelane_ecc_chk (
    input logic        clk,
    input logic        rst,
    input logic        ce_n,
    input logic        oe_n,
    input logic        we_n,
    input logic        lb_n,
    input logic        ub_n,
    input logic        inj_en,
    input logic [15:0] rdata,
    input logic [1:0]  rd_drive,
    input logic [1:0]  sec_flag,
    input logic [1:0]  unc_flag
);

    a_r3_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> rd_drive == 2'b00);

    a_r7_inject_no_access: assert property (@(posedge clk) disable iff (rst)
        inj_en |=> rd_drive == 2'b00);

    a_r2_read_drives_lower: assert property (@(posedge clk) disable iff (rst)
        (!inj_en && !ce_n && we_n && !oe_n && !lb_n) |=> rd_drive[0]);

    a_r2_read_drives_upper: assert property (@(posedge clk) disable iff (rst)
        (!inj_en && !ce_n && we_n && !oe_n && !ub_n) |=> rd_drive[1]);

    a_r1_write_no_drive: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !we_n) |=> rd_drive == 2'b00);

    a_r4_oe_blocks: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> rd_drive == 2'b00);

    a_r4_idle_lane_silent: assert property (@(posedge clk) disable iff (rst)
        (((sec_flag | unc_flag) & ~rd_drive) == 2'b00)
        && (rd_drive[0] || rdata[7:0] == 8'h00)
        && (rd_drive[1] || rdata[15:8] == 8'h00));

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        (sec_flag & unc_flag) == 2'b00);

    a_r8_reset_quiet: assert property (@(posedge clk)
        rst |=> (rd_drive == 2'b00 && rdata == 16'h0000));

endmodule

bind bytelane_ecc_ram bytelane_ecc_chk u_chk (.*);

// File: tb/sim_bytelane_ecc_ram.sv
module sim_bytelane_ecc_ram;

    localparam int CLK_P = 10;
    localparam int MAW   = 4;
    localparam int NW    = 1 << MAW;

    logic        clk = 1'b0;
    logic        rst;
    logic        ce_n, oe_n, we_n, lb_n, ub_n;
    logic [17:0] addr;
    logic [15:0] wdata;
    logic        inj_en, inj_lane;
    logic [3:0]  inj_pos;
    logic [15:0] rdata;
    logic [1:0]  rd_drive, sec_flag, unc_flag;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] shadow [NW][2];

    bytelane_ecc_ram #(.ADDR_W(18), .MEM_AW(MAW)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wdata(wdata),
        .inj_en(inj_en), .inj_lane(inj_lane), .inj_pos(inj_pos),
        .rdata(rdata), .rd_drive(rd_drive), .sec_flag(sec_flag), .unc_flag(unc_flag)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_p2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // data bit index held at codeword position p (R9 layout)
    function automatic int didx(input int p);
        int n = 0;
        for (int q = 1; q < p; q++) if (!is_p2(q)) n++;
        return n;
    endfunction

    function automatic logic [15:0] sh_word(input int a);
        return {shadow[a][1], shadow[a][0]};
    endfunction

    task automatic idle_in();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
        inj_en = 1'b0; inj_lane = 1'b0; inj_pos = 4'd0;
        addr = '0; wdata = '0;
    endtask

    task automatic wr(input logic [17:0] a, input logic [15:0] d,
                      input logic lbn, input logic ubn, input logic cen);
        @(negedge clk);
        ce_n = cen; we_n = 1'b0; oe_n = 1'b0; lb_n = lbn; ub_n = ubn;
        addr = a; wdata = d;
        @(negedge clk);
        idle_in();
        if (!cen) begin
            if (!lbn) shadow[a[MAW-1:0]][0] = d[7:0];
            if (!ubn) shadow[a[MAW-1:0]][1] = d[15:8];
        end
    endtask

    task automatic inj(input int a, input int lane, input int pos,
                       input logic with_wr);
        @(negedge clk);
        inj_en = 1'b1; addr = 18'(a); inj_lane = lane[0]; inj_pos = 4'(pos);
        if (with_wr) begin
            ce_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0; wdata = 16'h5A5A;
        end
        @(negedge clk);
        idle_in();
    endtask

    task automatic rd(input logic [17:0] a, input logic oen, input logic lbn,
                      input logic ubn, input logic cen);
        @(negedge clk);
        ce_n = cen; we_n = 1'b1; oe_n = oen; lb_n = lbn; ub_n = ubn; addr = a;
        @(negedge clk);
    endtask

    task automatic rd_expect(input string req, input int a,
                             input logic [15:0] ed, input logic [1:0] es,
                             input logic [1:0] eu);
        rd(18'(a), 1'b0, 1'b0, 1'b0, 1'b0);
        chk(req, "rdata", 32'(rdata), 32'(ed));
        chk(req, "rd_drive", 32'(rd_drive), 32'h3);
        chk(req, "sec_flag", 32'(sec_flag), 32'(es));
        chk(req, "unc_flag", 32'(unc_flag), 32'(eu));
        idle_in();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        idle_in();
        repeat (3) @(negedge clk);
        chk("R8", "rd_drive in reset", 32'(rd_drive), 0);
        chk("R8", "rdata in reset", 32'(rdata), 0);
        chk("R8", "flags in reset", 32'({sec_flag, unc_flag}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8", "rd_drive after reset", 32'(rd_drive), 0);

        // R1/R2: fill and read back every word
        for (int a = 0; a < NW; a++) wr(18'(a), 16'(a * 16'h3B5) ^ 16'hA5C3, 1'b0, 1'b0, 1'b0);
        for (int a = 0; a < NW; a++) rd_expect("R2", a, sh_word(a), 2'b00, 2'b00);

        // R1: byte-masked writes leave the other lane alone
        for (int a = 0; a < NW; a++) begin
            wr(18'(a), ~sh_word(a), 1'b0, 1'b1, 1'b0);
            rd_expect("R1", a, sh_word(a), 2'b00, 2'b00);
            wr(18'(a), 16'(a * 16'h1111) ^ 16'h0F0F, 1'b1, 1'b0, 1'b0);
            rd_expect("R1", a, sh_word(a), 2'b00, 2'b00);
        end

        // R3: deselected write has no effect, deselected read drives nothing
        wr(18'd2, ~sh_word(2), 1'b0, 1'b0, 1'b1);
        rd_expect("R3", 2, sh_word(2), 2'b00, 2'b00);
        rd(18'd2, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R3", "rd_drive deselected", 32'(rd_drive), 0);
        chk("R3", "rdata deselected", 32'(rdata), 0);
        idle_in();

        // R4: output enable and byte enables gate the drive
        rd(18'd4, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R4", "rd_drive oe high", 32'(rd_drive), 0);
        chk("R4", "rdata oe high", 32'(rdata), 0);
        idle_in();
        rd(18'd4, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R4", "rd_drive lower off", 32'(rd_drive), 32'h2);
        chk("R4", "rdata lower off", 32'(rdata), 32'({shadow[4][1], 8'h00}));
        idle_in();
        rd(18'd4, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R4", "rd_drive upper off", 32'(rd_drive), 32'h1);
        chk("R4", "rdata upper off", 32'(rdata), 32'({8'h00, shadow[4][0]}));
        idle_in();

        // R10: upper address bits alias onto the same word
        wr(18'h2A005, 16'hC0DE, 1'b0, 1'b0, 1'b0);
        rd_expect("R10", 5, 16'hC0DE, 2'b00, 2'b00);

        // R5: every single-bit error in every lane of every word
        for (int a = 0; a < NW; a++) begin
            for (int l = 0; l < 2; l++) begin
                for (int p = 1; p <= 12; p++) begin
                    inj(a, l, p, 1'b0);
                    rd_expect("R5", a, sh_word(a), 2'(1 << l), 2'b00);
                    inj(a, l, p, 1'b0);
                end
            end
        end

        // R6/R9: position pairs whose syndrome lands on 13..15
        for (int a = 0; a < 4; a++) begin
            for (int l = 0; l < 2; l++) begin
                for (int p = 1; p <= 12; p++) begin
                    for (int q = p + 1; q <= 12; q++) begin
                        if ((p ^ q) >= 13) begin
                            logic [15:0] ed;
                            ed = sh_word(a);
                            if (!is_p2(p)) ed[l*8 + didx(p)] = ~ed[l*8 + didx(p)];
                            if (!is_p2(q)) ed[l*8 + didx(q)] = ~ed[l*8 + didx(q)];
                            inj(a, l, p, 1'b0);
                            inj(a, l, q, 1'b0);
                            rd_expect("R6", a, ed, 2'b00, 2'(1 << l));
                            inj(a, l, p, 1'b0);
                            inj(a, l, q, 1'b0);
                        end
                    end
                end
            end
        end

        // R7: injection wins over a simultaneous write
        inj(6, 1, 7, 1'b1);
        rd_expect("R7", 6, sh_word(6), 2'b10, 2'b00);
        inj(6, 1, 7, 1'b0);
        rd_expect("R7", 6, sh_word(6), 2'b00, 2'b00);

        // R7: out-of-range positions change nothing
        inj(7, 0, 0, 1'b0);
        rd_expect("R7", 7, sh_word(7), 2'b00, 2'b00);
        inj(7, 0, 13, 1'b0);
        rd_expect("R7", 7, sh_word(7), 2'b00, 2'b00);
        inj(7, 1, 15, 1'b0);
        rd_expect("R7", 7, sh_word(7), 2'b00, 2'b00);

        finish_run();
    end

endmodule